// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This peripheral holds four timer channels that count down on their own. Each channel has an enable, a clock divider of 1, 16 or 256, a 16-bit or 32-bit width and three behaviours at underflow: wrap to the maximum, reload from a stored value, or stop at zero. Software programs the channels through a 32-bit register port with an APB-style two-phase access. A common interrupt block collects one underflow flag per channel and drives a single interrupt line.

Each channel has two ways to set its count. A write to the load register replaces the live count on the next clock and also sets the stored reload value. A write to the background register changes only the reload value, so the running count is left alone and the new value is used at the next underflow. The register port is a control path, not a stream. It has no wait states and applies no back-pressure: every access completes in its access phase.

Top module: `tmr_unit`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. The shared registers are mask at 0x00, raw status at 0x04, masked status at 0x08 and clear at 0x0C. Channel n (0..3) uses base 0x10+0x10*n, with load at +0x0, live count at +0x4, control at +0x8 and background load at +0xC.
- R2: A write to a channel's load register sets the live count to the written value on the next cycle and sets the reload value. Both the load offset and the background offset read back the reload value.
- R3: A write to the background register changes only the reload value. The live count continues undisturbed.
- R4: While control bit 7 is set, the count decreases by one on each prescaled tick. Control bits [3:2] set the divider: 00 gives /1, 01 gives /16, 10 gives /256. A write to the load or control register restarts the divider, so the first decrement comes N cycles after that write. While bit 7 is clear the count holds.
- R5: With control bit 6 clear (free-running), an underflow from zero wraps the count to all ones for the selected width.
- R6: With control bit 6 set (periodic), an underflow loads the count from the reload value.
- R7: With control bit 0 set (one-shot), the first underflow leaves the count at zero with no further underflows. The enable bit stays set, and a load write starts the channel counting again.
- R8: With control bit 1 clear, only the low 16 bits count and wrap, and bits [31:16] of the live count read as 0. With bit 1 set, all 32 bits count.
- R9: Each underflow sets the channel's bit n in raw status. Writing 1 to bit n of the clear register clears that bit. Writes to raw status are ignored.
- R10: Masked status reads raw AND mask, and `irq` is high exactly when any masked bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Access select, held for setup and access phases |
| penable | input | 1 | High in the access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 6 | Word address, byte-offset bits [7:2] |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| irq | output | 1 | Combined interrupt |

## Verification
The checker assumes that `psel` is held through both phases, that `penable` is high only in the second phase, and that write data is stable while `penable` is high. The bench tasks always drive a setup cycle and then an access cycle, and change the pins only on falling edges. Expected counts come from a tick-by-tick model in the bench, indexed by the number of rising edges since the write that restarted the divider. Between scenarios the bench disables each channel and clears its status, so no leftover underflow reaches a later check.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CB_ONE  = 0;
  localparam int CB_WIDE = 1;
  localparam int CB_PSLO = 2;
  localparam int CB_PER  = 6;
  localparam int CB_EN   = 7;
  localparam int CTRL_W  = 8;

  localparam logic [1:0] W_LOAD = 2'd0;
  localparam logic [1:0] W_VAL  = 2'd1;
  localparam logic [1:0] W_CTRL = 2'd2;
  localparam logic [1:0] W_BG   = 2'd3;

  localparam logic [1:0] W_MASK = 2'd0;
  localparam logic [1:0] W_RAW  = 2'd1;
  localparam logic [1:0] W_MIS  = 2'd2;
  localparam logic [1:0] W_CLR  = 2'd3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PSW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PSW-1:0] cnt;
  logic [PSW-1:0] lim;

  always_comb begin
    case (sel)
      2'b00:   lim = '0;
      2'b01:   lim = PSW'(4'hF);
      default: lim = '1;
    endcase
  end

  assign tick = en && ((cnt & lim) == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !en) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DW  = 32,
  parameter int PSW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_load,
  input  logic              we_bg,
  input  logic              we_ctrl,
  input  logic [DW-1:0]     wdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DW-1:0]     count,
  output logic [DW-1:0]     value,
  output logic [DW-1:0]     reload,
  output logic              uf
);
  localparam int HW = DW / 2;

  logic tick, done, at_zero;

  tmr_prescale #(.PSW(PSW)) u_ps (
    .clk(clk), .rst_n(rst_n), .en(ctrl[CB_EN]),
    .restart(we_load | we_ctrl),
    .sel(ctrl[CB_PSLO+1:CB_PSLO]), .tick(tick)
  );

  assign value   = ctrl[CB_WIDE] ? count : {{(DW-HW){1'b0}}, count[HW-1:0]};
  assign at_zero = (value == '0);
  assign uf      = tick && at_zero && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
      ctrl   <= '0;
      done   <= 1'b0;
    end else begin
      if (we_ctrl) ctrl <= wdata[CTRL_W-1:0];
      if (we_load || we_bg) reload <= wdata;
      if (we_load) begin
        count <= wdata;
        done  <= 1'b0;
      end else begin
        if (we_ctrl) done <= 1'b0;
        if (tick && !done) begin
          if (!at_zero)             count <= value - 1'b1;
          else if (ctrl[CB_ONE])    done  <= 1'b1;
          else if (ctrl[CB_PER])    count <= reload;
          else                      count <= '1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] uf,
  input  logic              we_mask,
  input  logic              we_clr,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] raw,
  output logic              irq
);
  logic [NUM_CH-1:0] clr_bits;

  assign clr_bits = we_clr ? wdata : '0;
  assign irq      = |(raw & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      raw  <= '0;
    end else begin
      if (we_mask) mask <= wdata;
      raw <= (raw & ~clr_bits) | uf;
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int PSW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:2] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          irq
);
  localparam int SW = AW - 4;

  logic [SW-1:0] slot;
  logic [1:0]    word;
  logic          wr;

  logic [NUM_CH-1:0]             ld_we, bg_we, ctl_we, ch_uf;
  logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl;
  logic [NUM_CH-1:0][DW-1:0]     ch_cnt, ch_val, ch_rel;
  logic [NUM_CH-1:0]             irq_mask, irq_raw;
  logic                          mask_we, clr_we;

  assign slot    = paddr[AW-1:4];
  assign word    = paddr[3:2];
  assign wr      = psel && penable && pwrite;
  assign mask_we = wr && (slot == '0) && (word == W_MASK);
  assign clr_we  = wr && (slot == '0) && (word == W_CLR);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ld_we[g]  = wr && (slot == SW'(g + 1)) && (word == W_LOAD);
    assign bg_we[g]  = wr && (slot == SW'(g + 1)) && (word == W_BG);
    assign ctl_we[g] = wr && (slot == SW'(g + 1)) && (word == W_CTRL);

    tmr_channel #(.DW(DW), .PSW(PSW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .we_load(ld_we[g]), .we_bg(bg_we[g]), .we_ctrl(ctl_we[g]),
      .wdata(pwdata), .ctrl(ch_ctrl[g]), .count(ch_cnt[g]),
      .value(ch_val[g]), .reload(ch_rel[g]), .uf(ch_uf[g])
    );
  end

  tmr_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n), .uf(ch_uf),
    .we_mask(mask_we), .we_clr(clr_we), .wdata(pwdata[NUM_CH-1:0]),
    .mask(irq_mask), .raw(irq_raw), .irq(irq)
  );

  always_comb begin
    prdata = '0;
    if (slot == '0) begin
      case (word)
        W_MASK:  prdata = DW'(irq_mask);
        W_RAW:   prdata = DW'(irq_raw);
        W_MIS:   prdata = DW'(irq_raw & irq_mask);
        default: prdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (slot == SW'(i + 1)) begin
          case (word)
            W_VAL:   prdata = ch_val[i];
            W_CTRL:  prdata = DW'(ch_ctrl[i]);
            default: prdata = ch_rel[i];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          psel,
  input logic                          penable,
  input logic                          pwrite,
  input logic [AW-1:2]                 paddr,
  input logic [DW-1:0]                 pwdata,
  input logic [DW-1:0]                 prdata,
  input logic                          irq,
  input logic [NUM_CH-1:0]             ld_we,
  input logic [NUM_CH-1:0]             ctl_we,
  input logic [NUM_CH-1:0]             ch_uf,
  input logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl,
  input logic [NUM_CH-1:0][DW-1:0]     ch_cnt,
  input logic [NUM_CH-1:0][DW-1:0]     ch_val,
  input logic [NUM_CH-1:0]             irq_raw,
  input logic                          mask_we
);
  localparam int SW = AW - 4;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_c
    assert_load_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we[g] |=> ch_cnt[g] == $past(pwdata));

    assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_ctrl[g][CB_EN] && !ld_we[g]) |=> $stable(ch_cnt[g]));

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_uf[g] && ch_ctrl[g][CB_ONE] && !ld_we[g] && !ctl_we[g]) |=> ch_val[g] == '0);

    assert_narrow_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && !pwrite && paddr[AW-1:4] == SW'(g + 1) && paddr[3:2] == W_VAL
       && !ch_ctrl[g][CB_WIDE]) |-> prdata[DW-1:DW/2] == '0);

    assert_raw_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_uf[g] |=> irq_raw[g]);
  end

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|ch_uf) || mask_we));
endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq),
  .ld_we(ld_we), .ctl_we(ctl_we), .ch_uf(ch_uf), .ch_ctrl(ch_ctrl),
  .ch_cnt(ch_cnt), .ch_val(ch_val), .irq_raw(irq_raw), .mask_we(mask_we)
);

// File: tb/tb_tmr_unit.sv
`timescale 1ns/1ps
module tb_tmr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:2]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int checks = 0, failures = 0, cyc = 0, mark = 0, dcyc = 0;
  bit finished = 0;

  tmr_unit dut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] ca(input int ch, input int w);
    return 8'(16 + 16 * ch + 4 * w);
  endfunction

  function automatic logic [31:0] mdl(input logic [31:0] v, input logic [31:0] r,
                                      input bit per, input bit wide, input bit one, input int t);
    logic [31:0] c;
    bit done;
    c = wide ? v : (v & 32'hFFFF);
    done = 0;
    for (int i = 0; i < t; i++) begin
      if (!done) begin
        if (c == 0) begin
          if (one) done = 1;
          else if (per) c = wide ? r : (r & 32'hFFFF);
          else c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        end else c = c - 1;
      end
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a[7:2]; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(posedge clk);
    #1 mark = cyc;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a[7:2]; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata; dcyc = cyc;
    @(posedge clk);
    #1 psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 mask", d, 0);
    rd(8'h04, d); chk("R1 raw", d, 0);
    rd(8'h08, d); chk("R1 mis", d, 0);
    rd(ca(0, 1), d); chk("R1 ch0 value", d, 0);
    rd(ca(3, 2), d); chk("R1 ch3 ctrl", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_load();
    logic [31:0] d;
    wr(ca(0, 2), 32'h02);
    wr(ca(0, 0), 32'h1234_5678);
    rd(ca(0, 1), d); chk("R2 load immediate", d, 32'h1234_5678);
    wr(ca(0, 3), 32'h0000_00AA);
    rd(ca(0, 1), d); chk("R3 bg leaves count", d, 32'h1234_5678);
    rd(ca(0, 0), d); chk("R2 reload readback", d, 32'h0000_00AA);
    idle(20);
    rd(ca(0, 1), d); chk("R4 disabled holds", d, 32'h1234_5678);
    wr(ca(0, 2), 32'h00);
    rd(ca(0, 1), d); chk("R8 narrow read", d, 32'h0000_5678);
    wr(ca(0, 2), 32'h02);
    rd(ca(0, 1), d); chk("R8 wide read", d, 32'h1234_5678);
  endtask

  task automatic t_prescale(input int sel, input int div, input int wait_n);
    logic [31:0] d;
    wr(ca(1, 2), 32'h00);
    wr(ca(1, 0), 32'd5000);
    wr(ca(1, 2), 32'h82 | (sel << 2));
    idle(wait_n);
    rd(ca(1, 1), d);
    chk($sformatf("R4 divide by %0d", div), d, 32'd5000 - 32'((dcyc - mark) / div));
    wr(ca(1, 2), 32'h00);
  endtask

  task automatic t_free(input bit wide, input logic [31:0] v);
    logic [31:0] d;
    wr(ca(2, 2), 32'h00);
    wr(ca(2, 0), v);
    wr(ca(2, 2), wide ? 32'h82 : 32'h80);
    idle(8);
    rd(ca(2, 1), d);
    chk(wide ? "R5 wrap 32" : "R5 R8 wrap 16", d, mdl(v, v, 0, wide, 0, dcyc - mark));
    rd(8'h04, d); chk("R9 raw set", d & 32'h4, 32'h4);
    wr(ca(2, 2), 32'h00);
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R9 raw write ignored", d & 32'h4, 32'h4);
    wr(8'h0C, 32'h4);
    rd(8'h04, d); chk("R9 clear", d, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    int m0;
    wr(ca(1, 2), 32'h00);
    wr(ca(1, 0), 32'd50);
    wr(ca(1, 2), 32'hC2);
    m0 = mark;
    wr(ca(1, 3), 32'd7);
    rd(ca(1, 1), d); chk("R3 running count undisturbed", d, mdl(50, 7, 1, 1, 0, dcyc - m0));
    while (cyc - m0 < 54) @(posedge clk);
    rd(ca(1, 1), d); chk("R6 reload from background", d, mdl(50, 7, 1, 1, 0, dcyc - m0));
    idle(5);
    rd(ca(1, 1), d); chk("R6 second period", d, mdl(50, 7, 1, 1, 0, dcyc - m0));
    wr(ca(1, 2), 32'h00);
    wr(8'h0C, 32'hF);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(ca(3, 2), 32'h00);
    wr(ca(3, 0), 32'd3);
    wr(ca(3, 2), 32'h83);
    idle(20);
    rd(ca(3, 1), d); chk("R7 stops at zero", d, 0);
    rd(8'h04, d); chk("R7 raw once", d, 32'h8);
    wr(8'h0C, 32'h8);
    idle(20);
    rd(8'h04, d); chk("R7 no second underflow", d, 0);
    rd(ca(3, 2), d); chk("R7 enable kept", d, 32'h83);
    wr(ca(3, 0), 32'd6);
    rd(ca(3, 1), d); chk("R7 reload restarts", d, mdl(6, 6, 0, 1, 1, dcyc - mark));
    wr(ca(3, 2), 32'h00);
    wr(8'h0C, 32'hF);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(ca(0, 2), 32'h00);
    wr(ca(0, 0), 32'd0);
    wr(ca(0, 2), 32'h80);
    idle(4);
    rd(8'h04, d); chk("R9 raw ch0", d, 32'h1);
    chk("R10 irq masked off", {31'b0, irq}, 0);
    rd(8'h08, d); chk("R10 mis masked off", d, 0);
    wr(8'h00, 32'h1);
    chk("R10 irq on", {31'b0, irq}, 1);
    rd(8'h08, d); chk("R10 mis on", d, 32'h1);
    wr(8'h00, 32'h2);
    chk("R10 irq other mask", {31'b0, irq}, 0);
    wr(8'h0C, 32'h1);
    wr(8'h00, 32'h1);
    chk("R10 irq after clear", {31'b0, irq}, 0);
    rd(8'h00, d); chk("R10 mask readback", d, 32'h1);
    wr(ca(0, 2), 32'h00);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_load();
    t_prescale(0, 1, 30);
    t_prescale(1, 16, 100);
    t_prescale(2, 256, 700);
    t_free(0, 32'd2);
    t_free(1, 32'd1);
    t_periodic();
    t_oneshot();
    t_irq();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule